// File: doc/BRIEF.md
# Sampling converter bus interface controller

This block is the digital side of a multiplexed sampling converter. A host selects the chip with an active-low chip select. A sample/hold strobe picks one of several analog channels and starts a conversion. The conversion runs a coarse phase and then a fine phase, both timed by a clock-cycle counter. The finished code goes into a result register and is flagged by an active-low interrupt. A read strobe places that register on a tri-state data bus and, when it is released, clears the interrupt. The converter's analog front end is not modelled. Instead, each channel's present code is supplied on a packed input port, and the block holds the selected code at the instant the sampling phase ends.

The block has two interface modes, chosen by a static input. In separate-strobe mode, sample/hold controls the start, and its release ends sampling and hands over to the fine phase. In tied mode, the host drives sample/hold and read from one signal. A low level on that signal starts a conversion and also reads, while an internal coarse timer ends the sampling phase. In both modes the bus keeps showing the previous result until the interrupt falls. A start that arrives while a conversion is still running is dropped and recorded in a sticky flag.

Every strobe is gated by chip select first. The gated strobes and the channel-select lines then pass through a two-flop synchronizer before any edge detection.

Top module: `adc_bus_ctrl`

## Requirements
- R1: When cs_n is high, sh_n and rd_n have no effect. No conversion starts, int_n does not change, the result register does not change and bus_oe stays 0.
- R2: The channel is the value of sel at the start of the gated sample/hold. Codes 0, 1, 2 and 3 pick ain[9:0], ain[19:10], ain[29:20] and ain[39:30] respectively.
- R3: Separate mode (tied_mode=0) holds the selected code at the second clock edge after the first edge that sees the gated strobe released. int_n then falls FINE_CYC+3 edges after that first edge, and the result equals the held code.
- R4: In separate mode, sample_short is set at the end of a sampling phase if the gated strobe was seen low on fewer than MIN_SAMPLE_CYC edges; a strobe seen low on exactly MIN_SAMPLE_CYC edges does not set it. sample_short is cleared when the next conversion starts.
- R5: int_n returns high on the second edge after the first edge that sees the gated read released. If that edge is the same edge on which a new result is loaded, int_n stays low.
- R6: In tied mode (tied_mode=1), a coarse timer of COARSE_CYC cycles ends sampling with no strobe edge. int_n falls COARSE_CYC+FINE_CYC+3 edges after the first edge that sees the combined strobe low.
- R7: The result register, and so the bus contents, change only on the edge where int_n falls. Until then the bus shows the previous result.
- R8: bus_oe is 1 and data_bus carries the result only while cs_n and rd_n are both low. Otherwise data_bus is high impedance.
- R9: A new gated sample/hold start seen while a conversion is in progress is ignored. It sets overrun, which stays set until reset.
- R10: After reset, int_n is 1, overrun and sample_short are 0, and the result register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tied_mode | input | 1 | 0: separate strobes, 1: sample/hold and read tied |
| cs_n | input | 1 | Active-low chip select |
| sh_n | input | 1 | Active-low sample/hold strobe |
| rd_n | input | 1 | Active-low read strobe |
| sel | input | SELW (2) | Channel select |
| ain | input | NCH*W (40) | Packed per-channel conversion codes |
| int_n | output | 1 | Active-low result-ready interrupt |
| data_bus | output | W (10) | Tri-state result bus |
| bus_oe | output | 1 | High while data_bus is driven |
| sample_short | output | 1 | Last sampling phase was shorter than the minimum |
| overrun | output | 1 | Sticky: a start was dropped during a conversion |

## Verification
Two events can land on the same clock edge: the loading of a new result, which pulls int_n low, and the read-release edge detection, which pulls it high. The bench holds read low while a second conversion runs and times the read release so that its detection edge is exactly the completion edge. It then expects int_n to stay low and the bus to carry the new code. A per-cycle behavioural model is compared against the block on every clock, so any disagreement in the edges around that coincidence is reported. Directed checks also measure the cycle distance from strobe to interrupt.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_FINE   = 2'd2
  } conv_phase_e;
endpackage

// File: rtl/adc_sync2.sv
// Two-flop synchronizer for a vector of asynchronous levels.
module adc_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      sync_out <= '0;
    end else begin
      meta_q   <= async_in;
      sync_out <= meta_q;
    end
  end
endmodule

// File: rtl/adc_conv_seq.sv
// Conversion sequencer: start detection, channel capture, sampling and fine timers.
module adc_conv_seq
  import adc_bus_pkg::*;
#(
  parameter int W              = 10,
  parameter int NCH            = 4,
  parameter int SELW           = 2,
  parameter int MIN_SAMPLE_CYC = 38,
  parameter int COARSE_CYC     = 28,
  parameter int FINE_CYC       = 90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tied_mode,
  input  logic              sh_act,
  input  logic [SELW-1:0]   sel_s,
  input  logic [NCH*W-1:0]  ain,
  output logic              done,
  output logic [W-1:0]      hold_q,
  output logic              sample_short,
  output logic              overrun,
  output conv_phase_e       phase
);
  localparam int MAXC = (MIN_SAMPLE_CYC > COARSE_CYC)
                        ? ((MIN_SAMPLE_CYC > FINE_CYC) ? MIN_SAMPLE_CYC : FINE_CYC)
                        : ((COARSE_CYC > FINE_CYC) ? COARSE_CYC : FINE_CYC);
  localparam int CNTW = $clog2(MAXC + 1);
  localparam logic [CNTW-1:0] COARSE_LAST = CNTW'(COARSE_CYC - 1);
  localparam logic [CNTW-1:0] FINE_LAST   = CNTW'(FINE_CYC - 1);
  localparam logic [CNTW-1:0] SHORT_LIM   = CNTW'(MIN_SAMPLE_CYC - 1);

  logic            sh_prev;
  logic [CNTW-1:0] cnt;
  logic [SELW-1:0] ch_q;
  logic            start;
  logic [W-1:0]    ch_code;

  assign start   = sh_act & ~sh_prev;
  assign ch_code = ain[int'(ch_q)*W +: W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_prev      <= 1'b0;
      cnt          <= '0;
      ch_q         <= '0;
      done         <= 1'b0;
      hold_q       <= '0;
      sample_short <= 1'b0;
      overrun      <= 1'b0;
      phase        <= PH_IDLE;
    end else begin
      sh_prev <= sh_act;
      done    <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase        <= PH_SAMPLE;
            ch_q         <= sel_s;
            cnt          <= '0;
            sample_short <= 1'b0;
          end
        end
        PH_SAMPLE: begin
          if (start) overrun <= 1'b1;
          if (tied_mode) begin
            if (cnt == COARSE_LAST) begin
              hold_q <= ch_code;
              phase  <= PH_FINE;
              cnt    <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else if (sh_act) begin
            if (cnt != '1) cnt <= cnt + 1'b1;
          end else begin
            sample_short <= (cnt < SHORT_LIM);
            hold_q       <= ch_code;
            phase        <= PH_FINE;
            cnt          <= '0;
          end
        end
        PH_FINE: begin
          if (start) overrun <= 1'b1;
          if (cnt == FINE_LAST) begin
            done  <= 1'b1;
            phase <= PH_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_out_stage.sv
// Result register, interrupt flag and tri-state bus driver.
module adc_out_stage #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         done,
  input  logic [W-1:0] hold_val,
  input  logic         rd_act,
  input  logic         rd_pin_act,
  output logic         int_n,
  output logic [W-1:0] res_q,
  output logic         bus_oe,
  output logic [W-1:0] data_bus
);
  logic rd_prev;
  logic rd_rise;

  assign rd_rise = rd_prev & ~rd_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev <= 1'b0;
      int_n   <= 1'b1;
      res_q   <= '0;
    end else begin
      rd_prev <= rd_act;
      if (done) begin
        res_q <= hold_val;
        int_n <= 1'b0;
      end else if (rd_rise) begin
        int_n <= 1'b1;
      end
    end
  end

  assign bus_oe   = rd_pin_act;
  assign data_bus = rd_pin_act ? res_q : {W{1'bz}};
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
  import adc_bus_pkg::*;
#(
  parameter int W              = 10,
  parameter int NCH            = 4,
  parameter int SELW           = (NCH > 1) ? $clog2(NCH) : 1,
  parameter int MIN_SAMPLE_CYC = 38,
  parameter int COARSE_CYC     = 28,
  parameter int FINE_CYC       = 90
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tied_mode,
  input  logic             cs_n,
  input  logic             sh_n,
  input  logic             rd_n,
  input  logic [SELW-1:0]  sel,
  input  logic [NCH*W-1:0] ain,
  output logic             int_n,
  output logic [W-1:0]     data_bus,
  output logic             bus_oe,
  output logic             sample_short,
  output logic             overrun
);
  localparam int SYNW = SELW + 2;

  logic            sh_gate, rd_gate;
  logic [SYNW-1:0] syn_in, syn_out;
  logic            conv_done;
  logic [W-1:0]    hold_q;
  logic [W-1:0]    res_q;
  conv_phase_e     phase;

  assign sh_gate = ~cs_n & ~sh_n;
  assign rd_gate = ~cs_n & ~rd_n;
  assign syn_in  = {sel, sh_gate, rd_gate};

  adc_sync2 #(.W(SYNW)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (syn_in),
    .sync_out (syn_out)
  );

  adc_conv_seq #(
    .W(W), .NCH(NCH), .SELW(SELW),
    .MIN_SAMPLE_CYC(MIN_SAMPLE_CYC), .COARSE_CYC(COARSE_CYC), .FINE_CYC(FINE_CYC)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .tied_mode    (tied_mode),
    .sh_act       (syn_out[1]),
    .sel_s        (syn_out[SYNW-1:2]),
    .ain          (ain),
    .done         (conv_done),
    .hold_q       (hold_q),
    .sample_short (sample_short),
    .overrun      (overrun),
    .phase        (phase)
  );

  adc_out_stage #(.W(W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (conv_done),
    .hold_val   (hold_q),
    .rd_act     (syn_out[0]),
    .rd_pin_act (rd_gate),
    .int_n      (int_n),
    .res_q      (res_q),
    .bus_oe     (bus_oe),
    .data_bus   (data_bus)
  );
endmodule

// File: rtl/adc_bus_ctrl_chk.sv
module adc_bus_ctrl_chk
  import adc_bus_pkg::*;
#(
  parameter int W = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        rd_n,
  input logic        int_n,
  input logic        conv_done,
  input logic [W-1:0] res_q,
  input logic        overrun,
  input logic        sample_short,
  input conv_phase_e phase
);
  p_done_int_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !int_n);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(res_q));

  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  p_short_at_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_short) |-> $past(phase) == PH_SAMPLE);

  p_int_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_n) |-> $past(cs_n || rd_n, 3));
endmodule

bind adc_bus_ctrl adc_bus_ctrl_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_n         (cs_n),
  .rd_n         (rd_n),
  .int_n        (int_n),
  .conv_done    (conv_done),
  .res_q        (res_q),
  .overrun      (overrun),
  .sample_short (sample_short),
  .phase        (phase)
);

// File: tb/adc_bus_ctrl_tb.sv
module adc_bus_ctrl_tb;
  localparam int W = 10, NCH = 4, SELW = 2;
  localparam int MINS = 38, COARSE = 28, FINE = 90;

  logic clk = 1'b0, rst_n = 1'b0, tied_mode = 1'b0;
  logic cs_n = 1'b0, sh_n = 1'b1, rd_n = 1'b1;
  logic [SELW-1:0] sel = '0;
  logic [NCH*W-1:0] ain = '0;
  logic int_n, bus_oe, sample_short, overrun;
  wire  [W-1:0] data_bus;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  adc_bus_ctrl #(.W(W), .NCH(NCH), .MIN_SAMPLE_CYC(MINS), .COARSE_CYC(COARSE), .FINE_CYC(FINE)) u_dut (
    .clk(clk), .rst_n(rst_n), .tied_mode(tied_mode), .cs_n(cs_n), .sh_n(sh_n), .rd_n(rd_n),
    .sel(sel), .ain(ain), .int_n(int_n), .data_bus(data_bus), .bus_oe(bus_oe),
    .sample_short(sample_short), .overrun(overrun));

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit hs[4], hr[4];
  int hsel[4];
  int m_phase = 0, m_cnt = 0, m_ch = 0, m_hold = 0, m_res = 0;
  bit m_int = 1, m_short = 0, m_ovr = 0, m_done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin hs[i] = 0; hr[i] = 0; hsel[i] = 0; end
      m_phase = 0; m_cnt = 0; m_ch = 0; m_hold = 0; m_res = 0;
      m_int = 1; m_short = 0; m_ovr = 0; m_done = 0;
    end else begin
      bit st, rrise;
      for (int i = 3; i > 0; i--) begin hs[i] = hs[i-1]; hr[i] = hr[i-1]; hsel[i] = hsel[i-1]; end
      hs[0] = !cs_n && !sh_n; hr[0] = !cs_n && !rd_n; hsel[0] = int'(sel);
      st = hs[2] && !hs[3];
      rrise = hr[3] && !hr[2];
      if (m_done) begin m_res = m_hold; m_int = 0; end
      else if (rrise) m_int = 1;
      m_done = 0;
      if (m_phase == 0) begin
        if (st) begin m_phase = 1; m_ch = hsel[2]; m_cnt = 0; m_short = 0; end
      end else if (m_phase == 1) begin
        if (st) m_ovr = 1;
        if (tied_mode) begin
          if (m_cnt == COARSE - 1) begin m_hold = int'(ain[m_ch*W +: W]); m_phase = 2; m_cnt = 0; end
          else m_cnt++;
        end else if (hs[2]) m_cnt++;
        else begin
          m_short = (m_cnt + 1 < MINS);
          m_hold = int'(ain[m_ch*W +: W]); m_phase = 2; m_cnt = 0;
        end
      end else begin
        if (st) m_ovr = 1;
        if (m_cnt == FINE - 1) begin m_done = 1; m_phase = 0; end
        else m_cnt++;
      end
    end
    #1;
    if (rst_n && !finished) begin
      check("R5 int_n vs model", int'(int_n), int'(m_int));
      check("R9 overrun vs model", int'(overrun), int'(m_ovr));
      check("R4 sample_short vs model", int'(sample_short), int'(m_short));
      check("R8 bus_oe", int'(bus_oe), int'(!cs_n && !rd_n));
      if (bus_oe) check("R7 data_bus vs model", int'(data_bus), m_res);
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic set_code(int c, int v); ain[c*W +: W] = W'(v); endtask

  task automatic sample_pulse(int c, int len);
    sel = SELW'(c); sh_n = 1'b0;
    tick(len);
    sh_n = 1'b1;
  endtask

  task automatic wait_int(output int n);
    n = 0;
    while (int_n && n < 2000) begin tick(1); n++; end
  endtask

  task automatic read_expect(string tag, int exp);
    rd_n = 1'b0; #1;
    check(tag, int'(data_bus), exp);
    tick(1); rd_n = 1'b1; tick(4);
  endtask

  initial begin
    int n;
    tick(3); rst_n = 1'b1; tick(2);
    check("R10 int_n after reset", int'(int_n), 1);
    check("R10 overrun after reset", int'(overrun), 0);
    check("R10 sample_short after reset", int'(sample_short), 0);
    rd_n = 1'b0; #1; check("R10 result zero", int'(data_bus), 0); tick(1); rd_n = 1'b1; tick(4);

    // R3/R2: separate mode, input changes after hold
    set_code(2, 'h2A5);
    sample_pulse(2, 40);
    tick(5); set_code(2, 'h111);
    wait_int(n);
    check("R3 release to int latency", n + 5, FINE + 4);
    check("R4 no short flag", int'(sample_short), 0);
    read_expect("R3 held code", 'h2A5);
    check("R5 int released", int'(int_n), 1);

    // R2: each channel, exact minimum sample length (R4 boundary)
    for (int c = 0; c < NCH; c++) begin
      set_code(c, 'h40 + c * 'h55);
      sample_pulse(c, MINS);
      wait_int(n);
      check("R4 min length not short", int'(sample_short), 0);
      read_expect("R2 channel decode", 'h40 + c * 'h55);
    end

    // R4: one cycle short, then cleared by next start
    set_code(1, 'h3C3);
    sample_pulse(1, MINS - 1);
    wait_int(n);
    check("R4 short flagged", int'(sample_short), 1);
    read_expect("R4 short result", 'h3C3);
    sample_pulse(1, 50);
    tick(4);
    check("R4 cleared on new start", int'(sample_short), 0);
    wait_int(n); read_expect("R4 result", 'h3C3);

    // R1: chip select high blocks strobes
    cs_n = 1'b1; set_code(0, 'h0AA);
    sample_pulse(0, 40); rd_n = 1'b0;
    tick(FINE + 40);
    check("R1 int unchanged", int'(int_n), 1);
    check("R1/R8 bus not driven", int'(bus_oe), 0);
    rd_n = 1'b1; tick(2); cs_n = 1'b0; tick(2);
    read_expect("R1 result unchanged", 'h3C3);

    // R9: start during fine phase dropped
    set_code(3, 'h155);
    sample_pulse(3, 40);
    tick(20); set_code(3, 'h2EE);
    sample_pulse(0, 5);
    wait_int(n);
    check("R9 overrun set", int'(overrun), 1);
    read_expect("R9 dropped start kept result", 'h155);
    sample_pulse(3, 40); wait_int(n);
    check("R9 overrun sticky", int'(overrun), 1);
    read_expect("R9 next conv", 'h2EE);

    // R6/R7: tied mode, stale data until interrupt
    tied_mode = 1'b1; tick(2);
    set_code(0, 'h1F0);
    sel = 2'd0; sh_n = 1'b0; rd_n = 1'b0;
    n = 0;
    while (int_n && n < 2000) begin
      tick(1); n++;
      if (int_n) begin #1; check("R7 stale bus", int'(data_bus), 'h2EE); end
    end
    check("R6 tied latency", n, COARSE + FINE + 4);
    #1; check("R6 new result", int'(data_bus), 'h1F0);
    sh_n = 1'b1; rd_n = 1'b1; tick(5);
    check("R5 tied int released", int'(int_n), 1);
    tied_mode = 1'b0; tick(2);

    // R5: read release coincides with completion
    set_code(2, 'h0F0);
    sample_pulse(2, 40); wait_int(n);
    rd_n = 1'b0; tick(2);
    set_code(2, 'h30F);
    sample_pulse(2, 40);
    tick(FINE + 1); rd_n = 1'b1;
    tick(3);
    check("R5 completion wins over read release", int'(int_n), 0);
    read_expect("R5 new result present", 'h30F);
    check("R5 int cleared after next read", int'(int_n), 1);

    tick(5);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule